// File: doc/BRIEF.md
# Vertical Crosswise Column Multiplier

This block multiplies two unsigned 8-bit operands. It builds the 16-bit product one column at a time instead of summing rows of shifted partial products. The column with index k ANDs together every operand bit pair whose indices add up to k. It adds those bits to a carry word from the column below it. The lowest bit of that sum becomes product bit k, and the remaining bits move up to the next column as its carry. Every partial product is formed at once. The only serial path is the carry word passing through the fifteen column adders.

Operands are sampled on a rising edge on which `in_valid` is high. The product appears on `out_prod` with `out_valid` one edge after that. A new operand pair may be presented on every cycle, and results leave in the order they arrived. On a cycle with `in_valid` low, the operand pins are ignored and the last product stays on the output.

Top module: `vcm_mul`

## Requirements
- R1: A synchronous active-low reset forces `out_valid` to 0 and `out_prod` to 0 on the next rising edge.
- R2: `out_valid` is 1 on the second rising edge after an edge that sampled `in_valid` high. In every other case it is 0.
- R3: When `out_valid` is 1, `out_prod` equals the unsigned product of the `in_a` and `in_b` values sampled two edges earlier.
- R4: Product bit 0 is the AND of operand bit 0 of A and operand bit 0 of B. The lowest column has no incoming carry.
- R5: The carry that leaves the top column is a single bit and forms product bit 15. For example, 255 x 255 gives 0xFE01, with bit 15 set. The upper bits of that final carry are always zero.
- R6: Product bit k is the least significant bit of column k's sum, and the other bits of that sum are carried into column k+1. A one-hot A with bit i set, times a one-hot B with bit j set, gives a product with only bit i+j set.
- R7: On a cycle with `in_valid` low, `in_a` and `in_b` have no effect. `out_prod` keeps the last product, and no result is produced for that cycle.
- R8: Operand pairs presented on consecutive cycles produce one result per cycle, in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks `in_a`/`in_b` as an operand pair to multiply |
| in_a | input | 8 | Multiplicand, unsigned |
| in_b | input | 8 | Multiplier, unsigned |
| out_valid | output | 1 | `out_prod` holds a new result this cycle |
| out_prod | output | 16 | Unsigned product |

## Verification
Each product is due on the second rising edge after the edge that captured its operands. The bench drives stimulus at falling edges and samples two falling edges later, so it keeps a two-deep history of expected values and operands. The sweep streams every one of the 65536 operand pairs back to back. At each sample point it compares `out_valid`, the whole product and bit 0 against values computed in the bench. Idle stretches, a single isolated pulse and a reset in the middle of the run are each sampled on the falling edge after the register that they affect.

// File: rtl/vcm_pkg.sv
// Package: vcm_pkg
// Purpose : column geometry helpers shared by the column multiplier.
// Assumes : column index k runs from 0 to 2*W-2 for W-bit operands.
package vcm_pkg;

    localparam int unsigned VCM_OPW_DEF = 8;

    // lowest A-bit index that has a partner in column k
    function automatic int col_lo(input int k, input int w);
        return (k > w - 1) ? (k - w + 1) : 0;
    endfunction

    // highest A-bit index that has a partner in column k
    function automatic int col_hi(input int k, input int w);
        return (k < w - 1) ? k : (w - 1);
    endfunction

    // carry word width: w partial products plus a carry below 2^cw needs cw+1 sum bits
    function automatic int carry_width(input int w);
        return $clog2(w) + 1;
    endfunction

endpackage

// File: rtl/vcm_column.sv
// Module : vcm_column
// Purpose: one column of the vertical-and-crosswise multiplier. It forms every
//          a[i]&b[j] with i+j==K, adds them to the incoming carry word, emits
//          the sum LSB as a product bit and passes the upper bits on as carry.
// Assumes: CW is wide enough that W + (2^CW - 1) fits in CW+1 bits.
module vcm_column #(
    parameter int W  = 8,
    parameter int K  = 0,
    parameter int CW = 4
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [CW-1:0] cin,
    output logic          rbit,
    output logic [CW-1:0] cout
);
    import vcm_pkg::*;

    localparam int LO = col_lo(K, W);
    localparam int HI = col_hi(K, W);
    localparam int NP = HI - LO + 1;

    logic [NP-1:0] pp;
    logic [CW:0]   sum;

    // partial products of this column, all formed in parallel
    for (genvar n = 0; n < NP; n++) begin : g_pp
        assign pp[n] = a[LO + n] & b[K - LO - n];
    end

    // column adder: incoming carry plus every partial product
    always_comb begin
        sum = {1'b0, cin};
        for (int n = 0; n < NP; n++) begin
            sum = sum + {{CW{1'b0}}, pp[n]};
        end
    end

    assign rbit = sum[0];
    assign cout = sum[CW:1];

endmodule

// File: rtl/vcm_array.sv
// Module : vcm_array
// Purpose: chains 2*W-1 columns. The carry word ripples from column 0 up to the
//          top column, and the final carry supplies the product MSB.
// Assumes: purely combinational; column 0 sees a zero carry.
module vcm_array #(
    parameter int W = 8
) (
    input  logic [W-1:0]                      a,
    input  logic [W-1:0]                      b,
    output logic [2*W-1:0]                    prod,
    output logic [vcm_pkg::carry_width(W)-2:0] spill
);
    import vcm_pkg::*;

    localparam int NC = 2 * W - 1;
    localparam int CW = carry_width(W);

    logic [CW-1:0] carry [0:NC];
    logic [NC-1:0] rbits;

    assign carry[0] = '0;

    // one column per product bit below the MSB
    for (genvar k = 0; k < NC; k++) begin : g_col
        vcm_column #(.W(W), .K(k), .CW(CW)) u_col (
            .a    (a),
            .b    (b),
            .cin  (carry[k]),
            .rbit (rbits[k]),
            .cout (carry[k+1])
        );
    end

    assign prod  = {carry[NC][0], rbits};
    assign spill = carry[NC][CW-1:1];

endmodule

// File: rtl/vcm_mul.sv
// Module : vcm_mul
// Purpose: registered unsigned W x W multiplier built from the column array.
//          Operands are captured on in_valid; the product is registered one edge later.
// Assumes: synchronous active-low reset; one operand pair accepted per cycle.
module vcm_mul #(
    parameter int W = vcm_pkg::VCM_OPW_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [W-1:0]   in_a,
    input  logic [W-1:0]   in_b,
    output logic           out_valid,
    output logic [2*W-1:0] out_prod
);
    import vcm_pkg::*;

    localparam int PW = 2 * W;
    localparam int CW = carry_width(W);

    logic [W-1:0]  a_q;
    logic [W-1:0]  b_q;
    logic          v_q;
    logic [PW-1:0] prod_c;
    logic [CW-2:0] spill_c;

    // operand stage: capture the pair only when in_valid is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
            v_q <= 1'b0;
        end else begin
            v_q <= in_valid;
            if (in_valid) begin
                a_q <= in_a;
                b_q <= in_b;
            end
        end
    end

    vcm_array #(.W(W)) u_arr (
        .a     (a_q),
        .b     (b_q),
        .prod  (prod_c),
        .spill (spill_c)
    );

    // result stage: register the product behind its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_prod  <= '0;
        end else begin
            out_valid <= v_q;
            if (v_q) begin
                out_prod <= prod_c;
            end
        end
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_prod == '0));

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    p_product_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_prod == (PW'($past(a_q)) * PW'($past(b_q))));

    p_col0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_prod[0] == ($past(a_q[0]) & $past(b_q[0])));

    p_final_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        v_q |-> spill_c == '0);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !v_q |=> ($stable(out_prod) && !out_valid));

endmodule

// File: tb/sim_vcm_mul.sv
`timescale 1ns/1ps
module sim_vcm_mul;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_a = '0;
    logic [7:0]  in_b = '0;
    logic        out_valid;
    logic [15:0] out_prod;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    vcm_mul #(.W(8)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_prod  (out_prod)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string tag_for(input logic [7:0] a, input logic [7:0] b);
        if (a == 8'hFF && b == 8'hFF) return "R5";
        if ($onehot(a) && $onehot(b)) return "R6";
        return "R3";
    endfunction

    initial begin
        logic [15:0] e1 = '0, e2 = '0;
        logic [7:0]  a1 = '0, b1 = '0, a2 = '0, b2 = '0;
        bit          v1 = 1'b0, v2 = 1'b0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(out_prod == 16'h0, "R1 out_prod", out_prod, 0);
        rst_n = 1'b1;

        // R8/R3/R2/R4/R5/R6: back-to-back sweep of all operand pairs
        for (int n = 0; n < 65536 + 2; n++) begin
            @(negedge clk);
            if (v2) begin
                chk(out_valid == 1'b1, "R2 valid due", out_valid, 1);
                chk(out_prod == e2, tag_for(a2, b2), out_prod, e2);
                chk(out_prod[0] == (a2[0] & b2[0]), "R4", out_prod[0], a2[0] & b2[0]);
            end else begin
                chk(out_valid == 1'b0, "R2 idle", out_valid, 0);
            end
            e2 = e1; a2 = a1; b2 = b1; v2 = v1;
            if (n < 65536) begin
                a1 = n[15:8];
                b1 = n[7:0];
                e1 = 16'(a1) * 16'(b1);
                v1 = 1'b1;
                in_a = a1;
                in_b = b1;
                in_valid = 1'b1;
            end else begin
                v1 = 1'b0;
                in_valid = 1'b0;
            end
        end

        // R7: operand pins wiggle with in_valid low; output holds 255*255
        for (int i = 0; i < 5; i++) begin
            in_a = 8'(i * 37 + 3);
            in_b = 8'(i * 91 + 7);
            @(negedge clk);
            chk(out_valid == 1'b0, "R7 no result", out_valid, 0);
            chk(out_prod == 16'hFE01, "R7 hold", out_prod, 16'hFE01);
        end

        // R2/R7: one isolated pulse, 13*11 = 143
        in_a = 8'd13; in_b = 8'd11; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_a = 8'hAA; in_b = 8'h55;
        chk(out_valid == 1'b0, "R2 not yet", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R2 pulse", out_valid, 1);
        chk(out_prod == 16'd143, "R3 pulse", out_prod, 143);
        @(negedge clk);
        chk(out_valid == 1'b0, "R2 single", out_valid, 0);
        chk(out_prod == 16'd143, "R7 after pulse", out_prod, 143);

        // R1: reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 mid out_valid", out_valid, 0);
        chk(out_prod == 16'h0, "R1 mid out_prod", out_prod, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule